// File: doc/BRIEF.md
# Handshake Interrupt Generator

This block raises two level interrupt lines, one toward the host and one toward the management controller. Each line is driven by edge events on handshake flags that sit in a shared control register elsewhere. A flag does not raise an interrupt while it simply stays set. An event is recorded only when a flag changes in the watched direction while that source is enabled. The recorded event then drives the line through the same enable.

The host side has a one-bit enable register. A write with bit 1 set acknowledges a pending host event. The controller side has a two-bit enable register and a two-bit status register. It acknowledges by writing the status register. Controller source 0 fires when the host-to-controller attention flag rises. Controller source 1 fires when the host-busy flag falls. The host source fires when the controller-to-host attention flag rises. Register reads return data in the cycle after the read strobe.

Top module: `bt_irq_unit`

## Requirements
- R1: The host enable register stores only bit 0 of a host write. Any host read returns that bit in bit 0 with bits 7..1 zero, so a write of 0xFF reads back 0x01.
- R2: The host pending flag is set only when `b2h_flag` goes from 0 to 1 (previous cycle 0, this cycle 1) while the host enable bit is 1. Enabling while the flag is already 1 sets nothing.
- R3: `h_irq` is registered and equals host pending AND host enable as they stood one cycle earlier. Clearing the enable lowers the line without losing the pending event, and setting the enable again raises it.
- R4: A host write with bit 1 set clears host pending. If a qualifying edge arrives in the same cycle, the edge wins and pending stays set.
- R5: The controller enable register (`c_addr`=0) and status register (`c_addr`=1) keep only bits 1..0 of a write, so a write of 0xFF reads back 0x03.
- R6: Status bit 0 is set when `h2b_flag` goes from 0 to 1 while controller enable bit 0 is 1.
- R7: Status bit 1 is set when `busy_flag` goes from 1 to 0 while controller enable bit 1 is 1. A rising `busy_flag` sets nothing.
- R8: `c_irq` is registered and equals the OR over both bits of (status AND enable) as they stood one cycle earlier.
- R9: A controller write to the status register loads bits 1..0 from the write data, and writing 0 acknowledges. An edge event in the same cycle still sets its status bit.
- R10: After reset, both enables, both pending sets, both read-data registers and both interrupt lines are 0.
- R11: A read strobe captures the addressed register into the read-data output on the next clock edge. Without a strobe, the output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| b2h_flag | input | 1 | Controller-to-host attention flag (host source) |
| h2b_flag | input | 1 | Host-to-controller attention flag (controller source 0) |
| busy_flag | input | 1 | Host-busy flag (controller source 1, falling edge) |
| h_wr | input | 1 | Host write strobe to the enable register |
| h_rd | input | 1 | Host read strobe of the enable register |
| h_wdata | input | 8 | Host write data (bit 0 enable, bit 1 acknowledge) |
| h_rdata | output | 8 | Host read data |
| h_irq | output | 1 | Interrupt toward the host |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe |
| c_addr | input | 1 | Controller register select: 0 enable, 1 status |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data |
| c_irq | output | 1 | Interrupt toward the controller |

## Verification
The hardest cases to reach are the collisions: an acknowledge landing in the same cycle as a fresh qualifying edge, and an enable being set while the source flag is already high. Directed sequences place the flag transition and the register write on the same clock edge for both sides, and they switch the enable on over a flag that is held high. A long stretch of random toggling of flags and strobes follows. It is compared cycle by cycle against a behavioural model, which covers the other overlaps between masking, acknowledge and edges.

// File: rtl/bt_irq_unit.sv
module bt_irq_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          b2h_flag,
  input  logic          h2b_flag,
  input  logic          busy_flag,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq,
  input  logic          c_wr,
  input  logic          c_rd,
  input  logic          c_addr,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic          c_irq
);
  localparam int CSRC = 2;

  logic            b2h_q, h2b_q, busy_q;
  logic            h_mask_q, h_pend_q;
  logic [CSRC-1:0] c_mask_q, c_stat_q;

  wire            h_evt = b2h_flag & ~b2h_q & h_mask_q;
  wire [CSRC-1:0] c_evt = {~busy_flag & busy_q, h2b_flag & ~h2b_q} & c_mask_q;
  wire [CSRC-1:0] c_base = (c_wr && c_addr) ? c_wdata[CSRC-1:0] : c_stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b2h_q    <= 1'b0;
      h2b_q    <= 1'b0;
      busy_q   <= 1'b0;
      h_mask_q <= 1'b0;
      h_pend_q <= 1'b0;
      h_irq    <= 1'b0;
      h_rdata  <= '0;
      c_mask_q <= '0;
      c_stat_q <= '0;
      c_irq    <= 1'b0;
      c_rdata  <= '0;
    end else begin
      b2h_q    <= b2h_flag;
      h2b_q    <= h2b_flag;
      busy_q   <= busy_flag;
      h_irq    <= h_pend_q & h_mask_q;
      c_irq    <= |(c_stat_q & c_mask_q);
      h_pend_q <= (h_pend_q & ~(h_wr & h_wdata[1])) | h_evt;
      if (h_wr) h_mask_q <= h_wdata[0];
      if (h_rd) h_rdata <= {{(DW-1){1'b0}}, h_mask_q};
      c_stat_q <= c_base | c_evt;
      if (c_wr && !c_addr) c_mask_q <= c_wdata[CSRC-1:0];
      if (c_rd) c_rdata <= {{(DW-CSRC){1'b0}}, (c_addr ? c_stat_q : c_mask_q)};
    end
  end
endmodule

// File: rtl/bt_irq_unit_chk.sv
module bt_irq_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          b2h_flag,
  input logic          b2h_q,
  input logic          h_mask_q,
  input logic          h_pend_q,
  input logic          h_wr,
  input logic [DW-1:0] h_wdata,
  input logic          h_rd,
  input logic [DW-1:0] h_rdata,
  input logic          h_irq,
  input logic          c_rd,
  input logic [DW-1:0] c_rdata,
  input logic [1:0]    c_stat_q,
  input logic [1:0]    c_mask_q,
  input logic          c_irq
);
  AST_HOST_RD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd |=> (h_rdata[DW-1:1] == '0)); // R1
  AST_HOST_PEND_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_pend_q) |-> $past(b2h_flag && !b2h_q && h_mask_q)); // R2
  AST_HOST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> $past(h_mask_q && h_pend_q)); // R3
  AST_HOST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_wdata[1] && !(b2h_flag && !b2h_q && h_mask_q)) |=> !h_pend_q); // R4
  AST_CTRL_RD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd |=> (c_rdata[DW-1:2] == '0)); // R5
  AST_CTRL_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    c_irq |-> $past(|(c_stat_q & c_mask_q))); // R8
endmodule

bind bt_irq_unit bt_irq_unit_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .b2h_flag(b2h_flag), .b2h_q(b2h_q),
  .h_mask_q(h_mask_q), .h_pend_q(h_pend_q), .h_wr(h_wr), .h_wdata(h_wdata),
  .h_rd(h_rd), .h_rdata(h_rdata), .h_irq(h_irq), .c_rd(c_rd), .c_rdata(c_rdata),
  .c_stat_q(c_stat_q), .c_mask_q(c_mask_q), .c_irq(c_irq)
);

// File: tb/bt_irq_unit_tb_top.sv
module bt_irq_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic b2h_flag = 0, h2b_flag = 0, busy_flag = 0;
  logic h_wr = 0, h_rd = 0, c_wr = 0, c_rd = 0, c_addr = 0;
  logic [7:0] h_wdata = 0, c_wdata = 0;
  logic [7:0] h_rdata, c_rdata;
  logic h_irq, c_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bt_irq_unit dut_i (.*);

  // behavioural reference
  int m_hmask, m_hpend, m_hirq, m_hrd, m_b2h, m_cmask, m_cstat, m_cirq, m_crd, m_h2b, m_busy;
  always @(posedge clk) begin
    int hm, hp, cm, cs, ev;
    if (!rst_n) begin
      m_hmask = 0; m_hpend = 0; m_hirq = 0; m_hrd = 0; m_b2h = 0;
      m_cmask = 0; m_cstat = 0; m_cirq = 0; m_crd = 0; m_h2b = 0; m_busy = 0;
    end else begin
      hm = m_hmask; hp = m_hpend; cm = m_cmask; cs = m_cstat;
      m_hirq = (hp != 0 && hm != 0) ? 1 : 0;
      m_cirq = ((cs & cm) != 0) ? 1 : 0;
      if (h_rd) m_hrd = hm;
      if (c_rd) m_crd = c_addr ? cs : cm;
      if (h_wr && h_wdata[1]) m_hpend = 0;
      if (b2h_flag && m_b2h == 0 && hm != 0) m_hpend = 1;
      if (h_wr) m_hmask = h_wdata[0];
      if (c_wr && c_addr) m_cstat = c_wdata & 3;
      ev = 0;
      if (h2b_flag && m_h2b == 0 && (cm & 1) != 0) ev = ev | 1;
      if (!busy_flag && m_busy == 1 && (cm & 2) != 0) ev = ev | 2;
      m_cstat = m_cstat | ev;
      if (c_wr && !c_addr) m_cmask = c_wdata & 3;
      m_b2h = b2h_flag; m_h2b = h2b_flag; m_busy = busy_flag;
    end
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(h_irq, m_hirq, "R3 h_irq model");
    check(c_irq, m_cirq, "R8 c_irq model");
    check(h_rdata, m_hrd, "R1/R11 h_rdata model");
    check(c_rdata, m_crd, "R5/R11 c_rdata model");
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic hwr(input logic [7:0] d);
    @(negedge clk); h_wr = 1; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask
  task automatic hrd();
    @(negedge clk); h_rd = 1;
    @(negedge clk); h_rd = 0;
  endtask
  task automatic cwr(input logic a, input logic [7:0] d);
    @(negedge clk); c_wr = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_wr = 0;
  endtask
  task automatic crd(input logic a);
    @(negedge clk); c_rd = 1; c_addr = a;
    @(negedge clk); c_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(h_irq, 0, "R10 h_irq"); check(c_irq, 0, "R10 c_irq");
    check(h_rdata, 0, "R10 h_rdata"); check(c_rdata, 0, "R10 c_rdata");
    rst_n = 1;
    idle(2);
    hrd(); check(h_rdata, 0, "R10 host enable after reset");
    // R1
    hwr(8'hFF); hrd(); check(h_rdata, 8'h01, "R1 host enable readback");
    hwr(8'h00); hrd(); check(h_rdata, 8'h00, "R11 read after clear");
    // R2: flag rises while disabled, then enable over a high flag
    b2h_flag = 1; idle(3); check(h_irq, 0, "R2 edge while disabled");
    hwr(8'h01); idle(3); check(h_irq, 0, "R2 enable over high flag");
    b2h_flag = 0; idle(1); b2h_flag = 1; idle(3); check(h_irq, 1, "R2 fresh edge");
    // R3 gating
    hwr(8'h00); idle(2); check(h_irq, 0, "R3 masked");
    hwr(8'h01); idle(2); check(h_irq, 1, "R3 unmasked keeps pending");
    // R4 acknowledge
    hwr(8'h02); idle(2); check(h_irq, 0, "R4 ack");
    hwr(8'h01); idle(2); check(h_irq, 0, "R4 pending cleared");
    b2h_flag = 0; idle(1);
    @(negedge clk); b2h_flag = 1; h_wr = 1; h_wdata = 8'h03;
    @(negedge clk); h_wr = 0;
    idle(2); check(h_irq, 1, "R4 edge beats ack");
    hwr(8'h02);
    // R5
    cwr(0, 8'hFF); crd(0); check(c_rdata, 8'h03, "R5 ctrl enable readback");
    cwr(1, 8'hFF); crd(1); check(c_rdata, 8'h03, "R5 ctrl status readback");
    cwr(1, 8'h00); cwr(0, 8'h00); idle(2); check(c_irq, 0, "R9 cleared");
    // R6
    h2b_flag = 1; idle(3); check(c_irq, 0, "R6 edge while disabled");
    crd(1); check(c_rdata, 0, "R6 no status while disabled");
    cwr(0, 8'h01); idle(2); check(c_irq, 0, "R6 enable over high flag");
    h2b_flag = 0; idle(1); h2b_flag = 1; idle(3); check(c_irq, 1, "R6 fresh edge");
    crd(1); check(c_rdata, 8'h01, "R6 status bit 0");
    // R9
    cwr(1, 8'h00); idle(2); check(c_irq, 0, "R9 ack");
    crd(1); check(c_rdata, 0, "R9 status zero");
    h2b_flag = 0; idle(1);
    @(negedge clk); h2b_flag = 1; c_wr = 1; c_addr = 1; c_wdata = 0;
    @(negedge clk); c_wr = 0;
    crd(1); check(c_rdata, 8'h01, "R9 edge beats ack");
    cwr(1, 8'h00);
    // R7
    cwr(0, 8'h02); busy_flag = 1; idle(3); check(c_irq, 0, "R7 rising busy ignored");
    crd(1); check(c_rdata, 0, "R7 no status on rise");
    busy_flag = 0; idle(3); check(c_irq, 1, "R7 falling busy");
    crd(1); check(c_rdata, 8'h02, "R7 status bit 1");
    // R8 gating
    cwr(0, 8'h00); idle(2); check(c_irq, 0, "R8 masked");
    cwr(0, 8'h02); idle(2); check(c_irq, 1, "R8 unmasked keeps status");
    cwr(1, 8'h00); idle(2);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      b2h_flag = ($urandom % 4) == 0 ? ~b2h_flag : b2h_flag;
      h2b_flag = ($urandom % 4) == 0 ? ~h2b_flag : h2b_flag;
      busy_flag = ($urandom % 4) == 0 ? ~busy_flag : busy_flag;
      h_wr = ($urandom % 6) == 0; h_wdata = 8'($urandom);
      h_rd = ($urandom % 3) == 0;
      c_wr = ($urandom % 6) == 0; c_addr = 1'($urandom); c_wdata = 8'($urandom);
      c_rd = ($urandom % 3) == 0;
    end
    @(negedge clk); h_wr = 0; c_wr = 0; h_rd = 0; c_rd = 0;
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule